// File: doc/BRIEF.md
# Multi-Mode Shift Execution Unit

This block is the shift stage of a 16-bit processor datapath. Given a register operand, it produces a shifted or rotated result and a set of condition flags in a single registered step. There are four shift flavours, chosen by a 2-bit operation select: arithmetic right, logical right, arithmetic left and circular right.

The shift distance is set by a 4-bit count field that comes from the instruction word. When that field is zero, the distance comes instead from the low four bits of a second register value, which the surrounding datapath supplies. When those bits are also zero, the distance is the full word width of 16. The surrounding pipeline fetches both register values. This unit only consumes them.

Each accepted operation produces the result and five flags one clock later:
- unsigned-greater-than-zero
- signed-greater-than-zero
- equal-to-zero
- carry
- overflow

The unit takes a new operation on any cycle where `in_valid` is high. Its outputs hold their values on cycles where `in_valid` is low.

Top module: `shift_unit`

## Requirements
- R1: With `op_sel` = 0, the result is `operand` shifted right by the effective count, with copies of bit 15 filling the vacated upper positions.
- R2: With `op_sel` = 1, the result is `operand` shifted right by the effective count, with zeros filling the vacated upper positions. Bit 15 of the result is therefore always 0.
- R3: With `op_sel` = 2, the result is `operand` shifted left by the effective count, with zeros filling the vacated lower positions.
- R4: With `op_sel` = 3, the result is `operand` rotated right by the effective count. Bits leaving position 0 re-enter at position 15.
- R5: When `cnt_field` is nonzero, the effective count is `cnt_field`, and `cnt_reg` has no effect.
- R6: When `cnt_field` is zero, the effective count is `cnt_reg[3:0]`. Bits 15..4 of `cnt_reg` have no effect.
- R7: When `cnt_field` and `cnt_reg[3:0]` are both zero, the effective count is 16.
- R8: `flg_carry` is the last bit shifted out of the operand.
  - For left shifts it is `operand[16-n]`.
  - For right shifts and rotates it is `operand[n-1]`, where n is the effective count.
- R9: `flg_ovf` is 1 for `op_sel` = 2 exactly when bit 15 changes value at any step of the one-bit-at-a-time shift sequence. For the other three modes it is 0.
- R10: Each of these flags is 1 under its own condition:
  - `flg_lgt` when the result is nonzero.
  - `flg_agt` when the result is nonzero and its bit 15 is 0.
  - `flg_eq` when the result is zero.
- R11: An operation presented with `in_valid` high appears on the outputs, with `out_valid` high, after the next rising clock edge. When `in_valid` is low at an edge, `out_valid` goes low after that edge, and `result` and all flags keep their values.
- R12: While `rst` is high at a clock edge, `out_valid`, `result` and all flags are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept an operation this cycle |
| op_sel | input | 2 | 0 arithmetic right, 1 logical right, 2 arithmetic left, 3 circular right |
| operand | input | 16 | Value to shift |
| cnt_field | input | 4 | Count from the instruction word |
| cnt_reg | input | 16 | Count register value, used when `cnt_field` is zero |
| out_valid | output | 1 | Result and flags belong to an accepted operation |
| result | output | 16 | Shifted value |
| flg_lgt | output | 1 | Result nonzero (unsigned greater than zero) |
| flg_agt | output | 1 | Result positive and nonzero as a signed value |
| flg_eq | output | 1 | Result equal to zero |
| flg_carry | output | 1 | Last bit shifted out |
| flg_ovf | output | 1 | Sign changed during an arithmetic left shift |

## Verification
The unit holds no state apart from its output register. A wrong internal value therefore shows up on `result` or on a flag in the very cycle after the operation is accepted, and it disappears with the next accepted operation.

The most likely internal errors are a wrong stage in the logarithmic shifter or a wrong count chosen by the count selector. Either one shows as a wrong result only for the count values whose binary form uses that stage or that selector path. For this reason every mode is swept across every count field and every count register value, on operands whose bit patterns tell fill, sign and wrap behaviour apart.

A carry or overflow error is visible only on the flag ports. An error there may appear only for operands whose sign bits differ near the top of the word, so these operands are placed in the sweep on purpose.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

    typedef enum logic [1:0] {
        OP_SRA = 2'd0,
        OP_SRL = 2'd1,
        OP_SLA = 2'd2,
        OP_SRC = 2'd3
    } shift_op_e;

    typedef struct packed {
        logic lgt;
        logic agt;
        logic eq;
        logic carry;
        logic ovf;
    } shift_flags_t;

    // Width needed to hold a count of 0 .. 2**cnt_w
    function automatic int amount_width(input int cnt_w);
        return cnt_w + 1;
    endfunction

endpackage

// File: rtl/shift_count_sel.sv
module shift_count_sel #(
    parameter int CNT_W = 4,
    parameter int AMT_W = CNT_W + 1
) (
    input  logic [CNT_W-1:0] field_cnt,
    input  logic [CNT_W-1:0] reg_cnt,
    output logic [AMT_W-1:0] amount
);
    localparam logic [AMT_W-1:0] FULL_COUNT = AMT_W'(1) << CNT_W;

    logic field_zero;
    logic reg_zero;

    assign field_zero = (field_cnt == '0);
    assign reg_zero   = (reg_cnt == '0);

    always_comb begin
        if (!field_zero)
            amount = {1'b0, field_cnt};
        else if (!reg_zero)
            amount = {1'b0, reg_cnt};
        else
            amount = FULL_COUNT;
    end
endmodule

// File: rtl/shift_core.sv
module shift_core
    import shift_unit_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int AMT_W  = 5
) (
    input  shift_op_e          op,
    input  logic [DATA_W-1:0]  din,
    input  logic [AMT_W-1:0]   amount,
    output logic [DATA_W-1:0]  dout
);
    logic [DATA_W-1:0] stage [0:AMT_W];

    assign stage[0] = din;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] shifted;

        assign x = stage[k];

        if (S < DATA_W) begin : g_part
            always_comb begin
                unique case (op)
                    OP_SRA:  shifted = {{S{x[DATA_W-1]}}, x[DATA_W-1:S]};
                    OP_SRL:  shifted = {{S{1'b0}}, x[DATA_W-1:S]};
                    OP_SLA:  shifted = {x[DATA_W-1-S:0], {S{1'b0}}};
                    default: shifted = {x[S-1:0], x[DATA_W-1:S]};
                endcase
            end
        end else begin : g_full
            always_comb begin
                unique case (op)
                    OP_SRA:  shifted = {DATA_W{x[DATA_W-1]}};
                    OP_SRL:  shifted = '0;
                    OP_SLA:  shifted = '0;
                    default: shifted = x;
                endcase
            end
        end

        assign stage[k+1] = amount[k] ? shifted : x;
    end

    assign dout = stage[AMT_W];
endmodule

// File: rtl/shift_side_bits.sv
module shift_side_bits
    import shift_unit_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int AMT_W  = 5
) (
    input  shift_op_e          op,
    input  logic [DATA_W-1:0]  din,
    input  logic [AMT_W-1:0]   amount,
    output logic               carry,
    output logic               ovf
);
    int n;
    assign n = int'(amount);

    // Carry: bit that leaves the word on the final one-bit step
    always_comb begin
        carry = 1'b0;
        if (n >= 1 && n <= DATA_W) begin
            if (op == OP_SLA)
                carry = din[DATA_W - n];
            else
                carry = din[n - 1];
        end
    end

    // Overflow: any bit that reaches the sign position differs from the original sign
    always_comb begin
        ovf = 1'b0;
        if (op == OP_SLA) begin
            for (int i = 1; i < DATA_W; i++) begin
                if (i <= n && din[DATA_W-1-i] != din[DATA_W-1])
                    ovf = 1'b1;
            end
            if (n >= DATA_W && din[DATA_W-1])
                ovf = 1'b1;
        end
    end
endmodule

// File: rtl/shift_flag_gen.sv
module shift_flag_gen
    import shift_unit_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] res,
    input  logic              carry,
    input  logic              ovf,
    output shift_flags_t      flags
);
    logic nonzero;
    assign nonzero = |res;

    always_comb begin
        flags.lgt   = nonzero;
        flags.agt   = nonzero & ~res[DATA_W-1];
        flags.eq    = ~nonzero;
        flags.carry = carry;
        flags.ovf   = ovf;
    end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_unit_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  cnt_field,
    input  logic [DATA_W-1:0] cnt_reg,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flg_lgt,
    output logic              flg_agt,
    output logic              flg_eq,
    output logic              flg_carry,
    output logic              flg_ovf
);
    localparam int AMT_W = amount_width(CNT_W);

    shift_op_e          op;
    logic [AMT_W-1:0]   amount;
    logic [DATA_W-1:0]  shifted;
    logic               side_carry;
    logic               side_ovf;
    shift_flags_t       flags_next;
    shift_flags_t       flags_q;
    logic [DATA_W-1:0]  result_q;
    logic               valid_q;

    assign op = shift_op_e'(op_sel);

    shift_count_sel #(.CNT_W(CNT_W), .AMT_W(AMT_W)) u_cnt (
        .field_cnt (cnt_field),
        .reg_cnt   (cnt_reg[CNT_W-1:0]),
        .amount    (amount)
    );

    shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
        .op     (op),
        .din    (operand),
        .amount (amount),
        .dout   (shifted)
    );

    shift_side_bits #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_side (
        .op     (op),
        .din    (operand),
        .amount (amount),
        .carry  (side_carry),
        .ovf    (side_ovf)
    );

    shift_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .res   (shifted),
        .carry (side_carry),
        .ovf   (side_ovf),
        .flags (flags_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            result_q <= '0;
            flags_q  <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                result_q <= shifted;
                flags_q  <= flags_next;
            end
        end
    end

    assign out_valid = valid_q;
    assign result    = result_q;
    assign flg_lgt   = flags_q.lgt;
    assign flg_agt   = flags_q.agt;
    assign flg_eq    = flags_q.eq;
    assign flg_carry = flags_q.carry;
    assign flg_ovf   = flags_q.ovf;
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        op_sel,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              flg_lgt,
    input logic              flg_agt,
    input logic              flg_eq,
    input logic              flg_carry,
    input logic              flg_ovf
);
    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_drops_valid_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_idle_holds_result_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result) && $stable(flg_carry) && $stable(flg_ovf));

    assert_zero_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flg_lgt != flg_eq));

    assert_signed_pos_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flg_agt) |-> (flg_lgt && !result[DATA_W-1]));

    assert_logical_msb_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'd1) |=> !result[DATA_W-1]);

    assert_rotate_carry_msb_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'd3) |=> (flg_carry == result[DATA_W-1]));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel != 2'd2) |=> !flg_ovf);
endmodule

bind shift_unit shift_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .out_valid (out_valid),
    .result    (result),
    .flg_lgt   (flg_lgt),
    .flg_agt   (flg_agt),
    .flg_eq    (flg_eq),
    .flg_carry (flg_carry),
    .flg_ovf   (flg_ovf)
);

// File: tb/tb_shift_unit.sv
module tb_shift_unit;
    localparam int W = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    op_sel = '0;
    logic [W-1:0]  operand = '0;
    logic [CW-1:0] cnt_field = '0;
    logic [W-1:0]  cnt_reg = '0;
    logic          out_valid;
    logic [W-1:0]  result;
    logic          flg_lgt, flg_agt, flg_eq, flg_carry, flg_ovf;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [W-1:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    shift_unit #(.DATA_W(W), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .operand(operand), .cnt_field(cnt_field), .cnt_reg(cnt_reg),
        .out_valid(out_valid), .result(result), .flg_lgt(flg_lgt),
        .flg_agt(flg_agt), .flg_eq(flg_eq), .flg_carry(flg_carry), .flg_ovf(flg_ovf)
    );

    function automatic logic [W-1:0] next_rand(input logic [W-1:0] s);
        return {s[W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic check(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (op %0d operand %h field %0d reg %h)",
                     tag, what, act, exp, op_sel, operand, cnt_field, cnt_reg);
        end
    endtask

    // One-bit-at-a-time model of the shift sequence
    task automatic model(input int op, input logic [W-1:0] din, input int n,
                         output logic [W-1:0] r, output logic c, output logic v);
        logic s0;
        r = din; c = 1'b0; v = 1'b0; s0 = din[W-1];
        for (int j = 0; j < n; j++) begin
            case (op)
                0: begin c = r[0]; r = {r[W-1], r[W-1:1]}; end
                1: begin c = r[0]; r = {1'b0, r[W-1:1]}; end
                2: begin c = r[W-1]; r = {r[W-2:0], 1'b0}; if (r[W-1] != s0) v = 1'b1; end
                default: begin c = r[0]; r = {r[0], r[W-1:1]}; end
            endcase
        end
    endtask

    task automatic run_vec(input int op, input logic [W-1:0] din, input logic [CW-1:0] fld, input logic [W-1:0] creg);
        logic [W-1:0] er;
        logic ec, ev;
        int n;
        string otag, ctag, tag;
        if (fld != 0) begin n = int'(fld); ctag = "R5"; end
        else if (creg[CW-1:0] != 0) begin n = int'(creg[CW-1:0]); ctag = "R6"; end
        else begin n = W; ctag = "R7"; end
        case (op)
            0: otag = "R1";
            1: otag = "R2";
            2: otag = "R3";
            default: otag = "R4";
        endcase
        tag = {otag, "/", ctag};
        model(op, din, n, er, ec, ev);
        @(negedge clk);
        in_valid = 1'b1; op_sel = 2'(op); operand = din; cnt_field = fld; cnt_reg = creg;
        @(negedge clk);
        check("R11", "out_valid", W'(out_valid), W'(1));
        check(tag, "result", result, er);
        check("R8", "carry", W'(flg_carry), W'(ec));
        check("R9", "overflow", W'(flg_ovf), W'(ev));
        check("R10", "lgt/agt/eq", {13'd0, flg_lgt, flg_agt, flg_eq},
              {13'd0, er != 0, (er != 0) && !er[W-1], er == 0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] ops [0:31];
        logic [W-1:0] held;
        ops[0] = 16'h0000; ops[1] = 16'hFFFF; ops[2] = 16'h8000; ops[3] = 16'h0001;
        ops[4] = 16'h7FFF; ops[5] = 16'h8001; ops[6] = 16'h5555; ops[7] = 16'hAAAA;
        ops[8] = 16'hC000; ops[9] = 16'h4000; ops[10] = 16'h1234; ops[11] = 16'hF00F;
        for (int i = 12; i < 32; i++) begin
            lfsr = next_rand(lfsr);
            ops[i] = lfsr;
        end

        // R12: reset clears outputs even with an operation presented
        in_valid = 1'b1; operand = 16'hFFFF; cnt_field = 4'd3;
        repeat (3) @(negedge clk);
        check("R12", "out_valid", W'(out_valid), W'(0));
        check("R12", "result", result, '0);
        check("R12", "flags", {11'd0, flg_lgt, flg_agt, flg_eq, flg_carry, flg_ovf}, '0);
        rst = 1'b0;
        in_valid = 1'b0;

        for (int op = 0; op < 4; op++) begin
            for (int k = 0; k < 32; k++) begin
                for (int f = 1; f < 16; f++) begin
                    lfsr = next_rand(lfsr);
                    run_vec(op, ops[k], CW'(f), lfsr);
                end
                for (int r = 0; r < 16; r++) begin
                    lfsr = next_rand(lfsr);
                    run_vec(op, ops[k], '0, {lfsr[W-1:CW], CW'(r)});
                end
            end
        end

        // R11: with in_valid low, outputs hold and out_valid drops
        run_vec(3, 16'h1234, 4'd4, 16'h0000);
        held = result;
        @(negedge clk);
        in_valid = 1'b0; operand = 16'h0F0F; cnt_field = 4'd1; op_sel = 2'd2;
        @(negedge clk);
        @(negedge clk);
        check("R11", "idle out_valid", W'(out_valid), W'(0));
        check("R11", "idle result held", result, held);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule